// File: doc/BRIEF.md
# Nanosecond Time-of-Day Counter

This block keeps a free-running time-of-day count in nanoseconds. The count is 44 bits of whole nanoseconds with 29 fraction bits below them. On every clock an unsigned fixed-point step is added to the whole value. The step has 3 integer bits and 29 fraction bits, so software sets the rate in fine steps by writing a new step value. A step of zero stops time, and software can then load a new time field by field.

Software reaches four 32-bit registers over a plain register bus with address, write strobe, write data, read strobe and registered read data. The count is split across three of these registers. A fourth register holds the step. The 40-bit upper part of the count can be read coherently: a read of the top field keeps a copy of the middle field, and the next read of the middle field returns that copy.

Top module: `tod_counter`

## Requirements
- R1: Each clock the step register is added to the 73-bit value {nanoseconds[43:0], fraction[28:0]}. The step's bit 0 aligns with fraction bit 0, so whole nanoseconds advance by floor(total added / 2^29).
- R2: The nanosecond count wraps modulo 2^44; 0xFFF_FFFF_FFFE plus 4 ns gives 2.
- R3: The step register is at byte address 0x0C, is read and written as 32 bits, and resets to 0x8000_0000, which is 4 ns per clock. Reset sets the count and fraction to zero.
- R4: With a step of zero and no time write, the count and the fraction hold their values.
- R5: Address 0x00 maps nanosecond bits [3:0] to data bits [3:0]. Address 0x04 maps nanosecond bits [35:4] to data bits [31:0]. A write replaces only that field, and the other fields keep their values.
- R6: Address 0x08 maps nanosecond bits [43:36]. A read returns them in data bits [7:0] with the upper bits zero. A write takes them from write data bits [15:8] and ignores all other data bits.
- R7: A write to any of the three time registers clears the fraction to zero.
- R8: In a cycle with a time-register write, the step is not added. The written field and the other fields hold exactly their pre-write values after that edge.
- R9: A read at 0x08 captures nanosecond bits [35:4]. The next read at 0x04 returns that captured value. Reads at 0x04 after that return the live field.
- R10: Read data is registered. It shows the value present at the clock edge where the read strobe is sampled, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
Two things can happen in the same cycle: a bus write to a time field and the per-clock step addition. The bench runs the counter at 4 ns per clock and writes the low field on a chosen edge. It then freezes the counter on the following edge and compares the full 44-bit count with the value expected when the write blocks that cycle's addition. A second overlap is a carry out of the middle field that falls between a top-field read and the middle-field read. The bench places that carry on purpose and expects the pre-carry middle value from the copy.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int NS_W       = 44;
    localparam int FRAC_W     = 29;
    localparam int INC_W      = 32;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 4;
    localparam int LOW_W      = 4;
    localparam int MAIN_W     = 32;
    localparam int TOP_W      = NS_W - LOW_W - MAIN_W;
    localparam int TOP_LANE   = 8;
    localparam int ACC_W      = NS_W + FRAC_W;
    localparam int MAIN_LSB   = LOW_W;
    localparam int TOP_LSB    = LOW_W + MAIN_W;
    localparam logic [INC_W-1:0] INC_DEFAULT = 32'h8000_0000;

    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_MAIN = 2'd1,
        SEL_TOP  = 2'd2,
        SEL_STEP = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    typedef struct packed {
        logic ld_low;
        logic ld_main;
        logic ld_top;
    } tod_load_t;

    function automatic reg_sel_e addr_to_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[3:2]);
    endfunction

endpackage

// File: rtl/tod_accum.sv
module tod_accum
    import tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] step,
    input  tod_load_t        load,
    input  logic [BUS_W-1:0] wdata,
    output tod_t             cur
);

    logic [ACC_W-1:0] sum;
    tod_t             nxt;
    logic             any_ld;

    assign any_ld = load.ld_low | load.ld_main | load.ld_top;
    assign sum    = cur + ACC_W'(step);

    always_comb begin
        if (any_ld) begin
            nxt      = cur;
            nxt.frac = '0;
            if (load.ld_low)
                nxt.ns[LOW_W-1:0] = wdata[LOW_W-1:0];
            if (load.ld_main)
                nxt.ns[TOP_LSB-1:MAIN_LSB] = wdata[MAIN_W-1:0];
            if (load.ld_top)
                nxt.ns[NS_W-1:TOP_LSB] = wdata[TOP_LANE+TOP_W-1:TOP_LANE];
        end else begin
            nxt = tod_t'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    logic unused_wdata;
    assign unused_wdata = ^{wdata[BUS_W-1:TOP_LANE+TOP_W], wdata[TOP_LANE-1:LOW_W]};

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (step == '0 && !any_ld) |=> $stable(cur)); // R4

    AST_TOP_LANE: assert property (@(posedge clk) disable iff (rst)
        load.ld_top |=> cur.ns[NS_W-1:TOP_LSB] == $past(wdata[TOP_LANE+TOP_W-1:TOP_LANE])); // R6

    AST_FRAC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        any_ld |=> cur.frac == '0); // R7

    AST_LOW_LOAD_ONLY: assert property (@(posedge clk) disable iff (rst)
        (load.ld_low && !load.ld_main && !load.ld_top)
        |=> cur.ns[NS_W-1:LOW_W] == $past(cur.ns[NS_W-1:LOW_W])); // R8

endmodule

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              rd,
    input  logic [NS_W-1:0]   ns_live,
    output logic [INC_W-1:0]  step,
    output tod_load_t         load,
    output logic [BUS_W-1:0]  rdata
);

    reg_sel_e          sel;
    logic [MAIN_W-1:0] shadow_q;
    logic              shadow_vld;
    logic [MAIN_W-1:0] main_live;
    logic [BUS_W-1:0]  rd_mux;

    assign sel       = addr_to_sel(addr);
    assign main_live = ns_live[TOP_LSB-1:MAIN_LSB];

    assign load.ld_low  = wr && (sel == SEL_LOW);
    assign load.ld_main = wr && (sel == SEL_MAIN);
    assign load.ld_top  = wr && (sel == SEL_TOP);

    always_comb begin
        unique case (sel)
            SEL_LOW:  rd_mux = BUS_W'(ns_live[LOW_W-1:0]);
            SEL_MAIN: rd_mux = shadow_vld ? shadow_q : main_live;
            SEL_TOP:  rd_mux = BUS_W'(ns_live[NS_W-1:TOP_LSB]);
            default:  rd_mux = step;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step       <= INC_DEFAULT;
            shadow_q   <= '0;
            shadow_vld <= 1'b0;
            rdata      <= '0;
        end else begin
            if (wr && sel == SEL_STEP)
                step <= wdata;
            if (rd) begin
                rdata <= rd_mux;
                if (sel == SEL_TOP) begin
                    shadow_q   <= main_live;
                    shadow_vld <= 1'b1;
                end else if (sel == SEL_MAIN) begin
                    shadow_vld <= 1'b0;
                end
            end
        end
    end

    logic unused_addr;
    assign unused_addr = ^addr[1:0];

    AST_STEP_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> step == INC_DEFAULT); // R3

    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == SEL_TOP) |=> (shadow_vld && shadow_q == $past(main_live))); // R9

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata)); // R10

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata
);

    logic [INC_W-1:0] step;
    tod_load_t        load;
    tod_t             cur;

    tod_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .rd      (bus_rd),
        .ns_live (cur.ns),
        .step    (step),
        .load    (load),
        .rdata   (bus_rdata)
    );

    tod_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .load  (load),
        .wdata (bus_wdata),
        .cur   (cur)
    );

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
        $countones({load.ld_low, load.ld_main, load.ld_top}) <= 1); // R5

endmodule

// File: tb/test_tod_counter.sv
`timescale 1ns/1ps
module test_tod_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [3:0] A_LOW  = 4'h0;
    localparam logic [3:0] A_MAIN = 4'h4;
    localparam logic [3:0] A_TOP  = 4'h8;
    localparam logic [3:0] A_STEP = 4'hC;

    localparam int NV = 5;
    localparam logic [31:0] V_STEP [NV] = '{32'h2000_0000, 32'h3000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0001};
    localparam int          V_IDLE [NV] = '{9, 6, 24, 99, 2};
    localparam logic [43:0] V_NS   [NV] = '{44'd10, 44'd10, 44'd100, 44'd799, 44'd0};

    tod_counter i_tod_counter (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_ns(input logic [43:0] v);
        wr(A_STEP, 32'h0);
        wr(A_LOW,  {28'h0, v[3:0]});
        wr(A_MAIN, v[35:4]);
        wr(A_TOP,  {16'h0, v[43:36], 8'h00});
    endtask

    task automatic read_ns(output logic [43:0] v);
        logic [31:0] lo, mid, hi;
        rd(A_LOW, lo);
        rd(A_TOP, hi);
        rd(A_MAIN, mid);
        v = {hi[7:0], mid, lo[3:0]};
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [43:0] t, t2;
        idle(3);
        rst = 1'b0;
        // R3 reset state and default 4 ns per clock
        rd(A_MAIN, d); chk("R3 main after reset", 64'(d), 64'd0);
        rd(A_LOW, d);  chk("R3 runs 4ns/clk", 64'(d), 64'd4);
        rd(A_STEP, d); chk("R3 step default", 64'(d), 64'h8000_0000);

        // R1 vector walk
        for (int k = 0; k < NV; k++) begin
            load_ns(44'd0);
            wr(A_STEP, V_STEP[k]);
            idle(V_IDLE[k]);
            wr(A_STEP, 32'h0);
            read_ns(t);
            chk($sformatf("R1 vector %0d", k), 64'(t), 64'(V_NS[k]));
        end

        // R4 freeze
        read_ns(t); idle(20); read_ns(t2);
        chk("R4 frozen count", 64'(t2), 64'(t));

        // R2 wrap
        load_ns(44'hFFF_FFFF_FFFE);
        wr(A_STEP, 32'h8000_0000);
        wr(A_STEP, 32'h0);
        read_ns(t); chk("R2 wrap", 64'(t), 64'd2);

        // R6 top lane and R5 field isolation
        load_ns(44'd0);
        wr(A_TOP, 32'hA5A5_12FF);
        rd(A_TOP, d);  chk("R6 top lane", 64'(d), 64'h12);
        wr(A_MAIN, 32'hDEAD_BEEF);
        read_ns(t);    chk("R5 fields isolated", 64'(t), 64'h12_DEAD_BEEF_0);
        wr(A_LOW, 32'hFFFF_FFF9);
        read_ns(t);    chk("R5 low field", 64'(t), 64'h12_DEAD_BEEF_9);

        // R7 fraction cleared by time write
        load_ns(44'd0);
        wr(A_STEP, 32'h1000_0000); wr(A_STEP, 32'h0);
        wr(A_LOW, 32'h0);
        wr(A_STEP, 32'h1000_0000); wr(A_STEP, 32'h0);
        read_ns(t); chk("R7 fraction cleared", 64'(t), 64'd0);

        // R8 write blocks the step in its cycle
        load_ns(44'd0);
        wr(A_STEP, 32'h8000_0000);
        idle(3);
        wr(A_LOW, 32'h3);
        wr(A_STEP, 32'h0);
        read_ns(t); chk("R8 write priority", 64'(t), 64'd7);

        // R9 coherent read across a middle-field carry
        load_ns(44'h05F_FFFF_FFF0);
        wr(A_STEP, 32'h8000_0000);
        rd(A_TOP, d);  chk("R9 top before carry", 64'(d), 64'h05);
        idle(10);
        rd(A_MAIN, d); chk("R9 shadow main", 64'(d), 64'hFFFF_FFFF);
        rd(A_MAIN, d); chk("R9 live main", 64'(d), 64'h2);
        rd(A_TOP, d);  chk("R9 top after carry", 64'(d), 64'h06);
        wr(A_STEP, 32'h0);

        // R10 read data holds without a read
        rd(A_STEP, d);
        idle(5);
        chk("R10 rdata holds", 64'(bus_rdata), 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule